// File: doc/BRIEF.md
# Byte/Word Arithmetic Logic Unit with Status Flag Word

This block is the arithmetic and logic stage of a small integer datapath. Each cycle in which `op_valid` is high it takes two operands, an operation code, a byte/word size select and an incoming carry. It computes a sum, a difference or a bitwise result, registers that result, and updates the status flags in a 16-bit flag word that it holds as state.

The flag word also holds three control flags. These are loaded through a separate write port and never touched by an operation. Some operations deliberately preserve some status flags. Increment and decrement keep the carry, and bitwise operations keep the auxiliary carry. Because of this the flag register carries history from one operation to the next, and the block is clocked rather than purely combinational. Compare updates the flags only and raises no result-write strobe.

Top module: `alu_flags`

## Requirements
- R1: After reset `flags` reads 16'hF002, `result` is 0 and `result_we` is 0. In the flag word, CF is bit 0, PF bit 2, AF bit 4, ZF bit 6, SF bit 7, TF bit 8, IF bit 9, DF bit 10 and OF bit 11. Bits 1 and 12–15 always read 1, and bits 3 and 5 always read 0.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, CMP=4, AND=5, OR=6, XOR=7, INC=8, DEC=9. INC and DEC apply +1/−1 to `opnd_a` and ignore `opnd_b`. With `word_mode`=0 only the low bytes of the operands are used and `result[15:8]` is 0. The result appears on `result` one cycle after the `op_valid` edge, and `result_we` pulses high for that one cycle.
- R3: CF is set on a carry out of the top bit of the selected size for ADD/ADC, or on a borrow into it for SUB/SBB/CMP. ADC adds `carry_in` and SBB subtracts it; the other operations ignore `carry_in`.
- R4: AF is set on a carry out of, or a borrow into, bit 3 for arithmetic operations. PF is set when `result[7:0]` holds an even number of ones, whatever the size.
- R5: ZF is set when the sized result is zero. SF copies bit 7 (byte) or bit 15 (word) of the result.
- R6: OF is set when the signed result does not fit the selected size, that is 8 bits in byte mode and 16 bits in word mode.
- R7: AND, OR and XOR clear CF and OF, set ZF, SF and PF from the result, and leave AF unchanged.
- R8: INC and DEC update PF, AF, ZF, SF and OF, and leave CF at its prior value.
- R9: CMP sets the flags exactly as SUB would. It leaves `result_we` low and `result` unchanged.
- R10: When `ctl_we` is high, TF, IF and DF load from `ctl_in[0]`, `ctl_in[1]` and `ctl_in[2]` at the next edge. No operation changes them.
- R11: A cycle with `op_valid` low, or with an operation code of 10–15, changes neither `flags` nor `result`, and leaves `result_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform the operation this cycle |
| op_code | input | 4 | Operation select (see R2) |
| word_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand (destination side) |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry/borrow for ADC and SBB |
| ctl_we | input | 1 | Load the control flags |
| ctl_in | input | 3 | New control flags {DF, IF, TF} |
| result | output | 16 | Registered result |
| result_we | output | 1 | Result-write strobe, one cycle per writing operation |
| flags | output | 16 | Flag word |

## Verification
The hardest states to reach from the ports are the ones where preserved flags must be told apart from freshly computed ones. An INC or DEC that must keep a carry of 1 can only be tested after an earlier operation has set that carry. Likewise, a bitwise operation that must keep AF can only be tested after an arithmetic operation has left AF at 1. The directed sequence therefore chains its operations. Each preserved-flag test follows an operation whose expected flags put a known 1 (or 0) in the flag under test. The byte-mode tests drive nonzero upper operand bytes, so that a leak of the upper byte into the carry, sign or overflow would show up.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic        word_mode,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic        carry_in,
  input  logic        ctl_we,
  input  logic [2:0]  ctl_in,
  output logic [15:0] result,
  output logic        result_we,
  output logic [15:0] flags
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
                         OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9;

  logic cf, pf, af, zf, sf, of, tf, ie, df;
  logic [15:0] res_q;
  logic        we_q;

  wire known    = op_code <= OP_DEC;
  wire is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
  wire is_step  = (op_code == OP_INC) || (op_code == OP_DEC);
  wire is_sub   = (op_code == OP_SUB) || (op_code == OP_SBB) ||
                  (op_code == OP_CMP) || (op_code == OP_DEC);
  wire use_cin  = (op_code == OP_ADC) || (op_code == OP_SBB);

  wire [15:0] am   = word_mode ? opnd_a : {8'h00, opnd_a[7:0]};
  wire [15:0] braw = is_step ? 16'h0001 : opnd_b;
  wire [15:0] bm   = word_mode ? braw : {8'h00, braw[7:0]};
  wire [16:0] cin  = {16'h0000, use_cin & carry_in};

  wire [16:0] ext = is_sub ? ({1'b0, am} - {1'b0, bm} - cin)
                           : ({1'b0, am} + {1'b0, bm} + cin);

  logic [15:0] logic_r;
  always_comb begin
    case (op_code)
      OP_AND:  logic_r = am & bm;
      OP_OR:   logic_r = am | bm;
      default: logic_r = am ^ bm;
    endcase
  end

  wire [15:0] arith_r = word_mode ? ext[15:0] : {8'h00, ext[7:0]};
  wire [15:0] res     = is_logic ? logic_r : arith_r;

  wire cy    = word_mode ? ext[16] : ext[8];
  wire a_msb = word_mode ? am[15] : am[7];
  wire b_msb = word_mode ? bm[15] : bm[7];
  wire r_msb = word_mode ? res[15] : res[7];
  wire ovf   = is_sub ? ((a_msb != b_msb) && (r_msb != a_msb))
                      : ((a_msb == b_msb) && (r_msb != a_msb));
  wire aux   = am[4] ^ bm[4] ^ res[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cf, pf, af, zf, sf, of} <= 6'b0;
      {tf, ie, df}             <= 3'b0;
      res_q                    <= 16'h0000;
      we_q                     <= 1'b0;
    end else begin
      we_q <= op_valid && known && (op_code != OP_CMP);
      if (op_valid && known) begin
        pf <= ~^res[7:0];
        zf <= (res == 16'h0000);
        sf <= r_msb;
        if (is_logic) begin
          cf <= 1'b0;
          of <= 1'b0;
        end else begin
          af <= aux;
          of <= ovf;
          if (!is_step) cf <= cy;
        end
        if (op_code != OP_CMP) res_q <= res;
      end
      if (ctl_we) {df, ie, tf} <= ctl_in;
    end
  end

  assign result    = res_q;
  assign result_we = we_q;
  assign flags     = {4'hF, of, df, ie, tf, sf, zf, 1'b0, af, 1'b0, pf, 1'b1, cf};
endmodule

module alu_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic        word_mode,
  input logic [15:0] opnd_a,
  input logic [15:0] opnd_b,
  input logic        carry_in,
  input logic        ctl_we,
  input logic [2:0]  ctl_in,
  input logic [15:0] result,
  input logic        result_we,
  input logic [15:0] flags
);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags[15:12] == 4'hF && flags[1] && !flags[3] && !flags[5]);

  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd4 |=> !result_we && $stable(result));

  a_r8_step_keeps_cf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 4'd8 || op_code == 4'd9) |=> flags[0] == $past(flags[0]));

  a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code >= 4'd5 && op_code <= 4'd7 |=>
      !flags[0] && !flags[11] && flags[4] == $past(flags[4]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !ctl_we |=> $stable(flags) && $stable(result) && !result_we);

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> flags[6] == (result == 16'h0000));

  a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> flags[2] == ~^result[7:0]);

  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(flags[10:8]));
endmodule

bind alu_flags alu_flags_chk u_chk (.*);

// File: tb/alu_flags_tb.sv
module alu_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic        word_mode = 1'b0;
  logic [15:0] opnd_a = 16'h0000;
  logic [15:0] opnd_b = 16'h0000;
  logic        carry_in = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_in = 3'b000;
  logic [15:0] result;
  logic        result_we;
  logic [15:0] flags;

  int checks = 0;
  int failures = 0;
  logic ctf = 1'b0, cif = 1'b0, cdf = 1'b0;

  always #2 clk = ~clk;

  alu_flags u_dut (.*);

  function automatic logic [15:0] fw(input logic c, p, a, z, s, o);
    return {4'hF, o, cdf, cif, ctf, s, z, 1'b0, a, 1'b0, p, 1'b1, c};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation, sample after the edge that registers it
  task automatic run(input logic [3:0] op, input logic wm, input logic [15:0] a, b,
                     input logic ci);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; word_mode = wm;
    opnd_a = a; opnd_b = b; carry_in = ci;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic op_chk(input string req, input logic [3:0] op, input logic wm,
                        input logic [15:0] a, b, input logic ci,
                        input logic [15:0] er, input logic ew, input logic [15:0] ef);
    run(op, wm, a, b, ci);
    chk({req, " result"}, result, er);
    chk({req, " strobe"}, {15'd0, result_we}, {15'd0, ew});
    chk({req, " flags"}, flags, ef);
  endtask

  task automatic t_reset();
    chk("R1 reset flags", flags, 16'hF002);
    chk("R1 reset result", result, 16'h0000);
    chk("R1 reset strobe", {15'd0, result_we}, 16'd0);
  endtask

  task automatic t_add();
    // R2 R3 R4 R5 R6: word 7FFF+1
    op_chk("R6 add word ovf", 4'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b1,
           16'h8000, 1'b1, fw(0, 1, 1, 0, 1, 1));
    @(negedge clk);
    chk("R2 strobe one cycle", {15'd0, result_we}, 16'd0);
    // byte FF+01 with junk in upper bytes
    op_chk("R3 add byte carry", 4'd0, 1'b0, 16'h12FF, 16'hAB01, 1'b0,
           16'h0000, 1'b1, fw(1, 1, 1, 1, 0, 0));
    op_chk("R3 adc word cin", 4'd1, 1'b1, 16'hFFFF, 16'h0000, 1'b1,
           16'h0000, 1'b1, fw(1, 1, 1, 1, 0, 0));
  endtask

  task automatic t_sub();
    op_chk("R4 sub byte aux", 4'd2, 1'b0, 16'h5510, 16'h0001, 1'b1,
           16'h000F, 1'b1, fw(0, 1, 1, 0, 0, 0));
    op_chk("R6 sub word ovf", 4'd2, 1'b1, 16'h8000, 16'h0001, 1'b0,
           16'h7FFF, 1'b1, fw(0, 1, 1, 0, 0, 1));
    op_chk("R3 sbb byte borrow", 4'd3, 1'b0, 16'hFF00, 16'h0000, 1'b1,
           16'h00FF, 1'b1, fw(1, 1, 1, 0, 1, 0));
  endtask

  task automatic t_cmp();
    op_chk("R9 cmp word", 4'd4, 1'b1, 16'h0005, 16'h0007, 1'b0,
           16'h00FF, 1'b0, fw(1, 0, 1, 0, 1, 0));
  endtask

  task automatic t_logic();
    // AF is 1 from the compare and must survive
    op_chk("R7 and word", 4'd5, 1'b1, 16'hF0F0, 16'h0FF0, 1'b1,
           16'h00F0, 1'b1, fw(0, 1, 1, 0, 0, 0));
    op_chk("R7 or byte", 4'd6, 1'b0, 16'h7780, 16'h0001, 1'b0,
           16'h0081, 1'b1, fw(0, 1, 1, 0, 1, 0));
    op_chk("R5 xor word zero", 4'd7, 1'b1, 16'hAAAA, 16'hAAAA, 1'b0,
           16'h0000, 1'b1, fw(0, 1, 1, 1, 0, 0));
  endtask

  task automatic t_step();
    run(4'd0, 1'b0, 16'h00FF, 16'h0001, 1'b0); // sets CF
    op_chk("R8 inc byte keeps cf=1", 4'd8, 1'b0, 16'h3C7F, 16'hFFFF, 1'b1,
           16'h0080, 1'b1, fw(1, 0, 1, 0, 1, 1));
    op_chk("R8 dec word keeps cf=1", 4'd9, 1'b1, 16'h0000, 16'h1234, 1'b0,
           16'hFFFF, 1'b1, fw(1, 1, 1, 0, 1, 0));
    op_chk("R2 sub word clears cf", 4'd2, 1'b1, 16'h0002, 16'h0001, 1'b0,
           16'h0001, 1'b1, fw(0, 0, 0, 0, 0, 0));
    op_chk("R8 dec word keeps cf=0", 4'd9, 1'b1, 16'h8000, 16'h0000, 1'b1,
           16'h7FFF, 1'b1, fw(0, 1, 1, 0, 0, 1));
  endtask

  task automatic t_ctl();
    @(negedge clk);
    ctl_we = 1'b1; ctl_in = 3'b101;
    @(negedge clk);
    ctl_we = 1'b0;
    ctf = 1'b1; cif = 1'b0; cdf = 1'b1;
    chk("R10 ctl load", flags, fw(0, 1, 1, 0, 0, 1));
    op_chk("R10 ctl kept by add", 4'd0, 1'b1, 16'h0001, 16'h0001, 1'b0,
           16'h0002, 1'b1, fw(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_idle();
    op_chk("R11 undefined opcode", 4'd12, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1,
           16'h0002, 1'b0, fw(0, 0, 0, 0, 0, 0));
    @(negedge clk);
    op_code = 4'd0; opnd_a = 16'hFFFF; opnd_b = 16'h0001; word_mode = 1'b1;
    @(negedge clk);
    chk("R11 op_valid low result", result, 16'h0002);
    chk("R11 op_valid low flags", flags, fw(0, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_step();
    t_ctl();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule